// File: doc/BRIEF.md
# Static Memory Write Cycle Sequencer

This block produces the strobe timing for a single write to an external asynchronous static memory or flash-type device. A request carries an address, write data, a bank number and a byte-lane mode flag. Each bank has two static settings: a strobe delay and a wait count. When the sequencer is idle it takes a request. It then drives a one-hot active-low chip select, the address, the data and an active-low write strobe or byte-lane strobes. It returns a one-cycle completion pulse.

Every access begins with a setup cycle in which chip select, address and data are valid but no strobe is active. The strobe phase runs up to and including cycle index 1 + wait. After it comes one hold cycle in which address and chip select stay valid. The wait count alone sets the length of the access. The strobe delay only moves the start of the strobe later inside that fixed window. A delay larger than the wait count is clamped to the wait count.

Top module: `smw_write_seq`

## Requirements
- R1: After reset, and whenever no access is in progress, every chip select, the write strobe and every byte-lane strobe are high, and the done output is low.
- R2: A request accepted at a clock edge drives the chip select of the requested bank low, and all others high, from the cycle after that edge (cycle index 0). In the same cycle the request's address and data appear on the memory outputs.
- R3: No strobe is low in cycle index 0. The strobe goes low in cycle index 1 + d, where d is the selected bank's delay setting.
- R4: The strobe stays low through cycle index 1 + w and is high from cycle index 2 + w, where w is the selected bank's wait setting.
- R5: Chip select stays low for exactly 3 + w cycles, whatever the delay setting is.
- R6: When the delay setting is larger than the wait setting, the block behaves as if the delay equalled the wait setting, so the strobe lasts one cycle.
- R7: With the byte-lane flag set, all byte-lane strobes follow the R3/R4 timing and the write strobe stays high. With the flag clear, the byte-lane strobes stay high.
- R8: Done is high for exactly one cycle, cycle index 2 + w, which is the hold cycle.
- R9: A request presented during an access, including at the edge that ends the hold cycle, is ignored. Address, data and chip select keep the values of the running access, and the bus returns to idle after the hold cycle.
- R10: The delay and wait settings used for an access are the pair belonging to the requested bank. Each bank has its own CNT_W-bit field at bit offset bank*CNT_W in the packed setting inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request, taken only while idle |
| req_addr | input | ADDR_W | Write address |
| req_wdata | input | DATA_W | Write data |
| req_bank | input | BANK_W | Target bank number |
| req_byte_mode | input | 1 | Use byte-lane strobes instead of the write strobe |
| cfg_wen_dly | input | NUM_BANKS*CNT_W | Per-bank strobe delay settings, packed |
| cfg_wr_wait | input | NUM_BANKS*CNT_W | Per-bank wait settings, packed |
| mem_cs_n | output | NUM_BANKS | Active-low chip selects, one per bank |
| mem_addr | output | ADDR_W | Address to memory |
| mem_dout | output | DATA_W | Write data to memory |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_lane_n | output | DATA_W/8 | Active-low byte-lane strobes |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench uses the default parameters: four banks, 4-bit setting fields, a 24-bit address and 16-bit data, which gives two byte lanes. With 4-bit fields, every delay and wait pair from 0 to 15 can be swept in both strobe modes. That covers the clamped half of the space and the longest 18-cycle access. With four banks, the requested bank's settings can be placed among differing settings in the other banks, and stray requests can target a neighbouring bank while an access runs.

// File: rtl/smw_pkg.sv
package smw_pkg;

    // Position of a cycle inside one write access
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    // Active-high intent for the memory-side strobes of one cycle
    typedef struct packed {
        logic cs;
        logic we;
        logic lane;
        logic done;
    } strobe_s;

    // Phase of cycle index idx for delay dly and wait wt (dly <= wt assumed)
    function automatic phase_e phase_at(input int unsigned idx,
                                        input int unsigned dly,
                                        input int unsigned wt);
        phase_e ph;
        if (idx < 1 + dly)
            ph = PH_SETUP;
        else if (idx <= 1 + wt)
            ph = PH_STROBE;
        else
            ph = PH_HOLD;
        return ph;
    endfunction

    // Strobe intent for a phase; byte_mode steers the strobe to the lanes
    function automatic strobe_s intent_of(input phase_e ph, input logic byte_mode);
        strobe_s s;
        s.cs   = (ph != PH_IDLE);
        s.we   = (ph == PH_STROBE) && !byte_mode;
        s.lane = (ph == PH_STROBE) && byte_mode;
        s.done = (ph == PH_HOLD);
        return s;
    endfunction

endpackage

// File: rtl/smw_cfg_sel.sv
module smw_cfg_sel #(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 4,
    parameter int BANK_W    = 2
) (
    input  logic [BANK_W-1:0]          bank,
    input  logic [NUM_BANKS*CNT_W-1:0] dly_flat,
    input  logic [NUM_BANKS*CNT_W-1:0] wait_flat,
    output logic [CNT_W-1:0]           dly_eff,
    output logic [CNT_W-1:0]           wait_sel
);

    logic [CNT_W-1:0] dly_arr  [NUM_BANKS];
    logic [CNT_W-1:0] wait_arr [NUM_BANKS];
    logic [CNT_W-1:0] dly_raw;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_unpack
        assign dly_arr[b]  = dly_flat[b*CNT_W +: CNT_W];
        assign wait_arr[b] = wait_flat[b*CNT_W +: CNT_W];
    end

    always_comb begin
        dly_raw  = '0;
        wait_sel = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == BANK_W'(b)) begin
                dly_raw  = dly_arr[b];
                wait_sel = wait_arr[b];
            end
        end
    end

    // Ordering rule: delay may not exceed wait; clamp otherwise
    assign dly_eff = (dly_raw > wait_sel) ? wait_sel : dly_raw;

endmodule

// File: rtl/smw_phase_ctr.sv
module smw_phase_ctr
    import smw_pkg::*;
#(
    parameter int CNT_W = 4,
    parameter int IDX_W = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] dly_in,
    input  logic [CNT_W-1:0] wait_in,
    output logic             active,
    output phase_e           phase_nxt
);

    localparam logic [IDX_W-1:0] HOLD_OFS = IDX_W'(2);

    logic [IDX_W-1:0] idx_q, idx_nxt;
    logic [CNT_W-1:0] dly_q, wait_q;
    logic             active_nxt;
    logic [IDX_W-1:0] last_idx;

    assign last_idx = IDX_W'(wait_q) + HOLD_OFS;

    always_comb begin
        idx_nxt    = idx_q;
        active_nxt = active;
        phase_nxt  = PH_IDLE;
        if (!active) begin
            if (start) begin
                idx_nxt    = '0;
                active_nxt = 1'b1;
                phase_nxt  = phase_at(32'd0, 32'(dly_in), 32'(wait_in));
            end
        end else if (idx_q == last_idx) begin
            active_nxt = 1'b0;
            phase_nxt  = PH_IDLE;
        end else begin
            idx_nxt   = idx_q + IDX_W'(1);
            phase_nxt = phase_at(32'(idx_nxt), 32'(dly_q), 32'(wait_q));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx_q  <= '0;
            dly_q  <= '0;
            wait_q <= '0;
        end else begin
            active <= active_nxt;
            idx_q  <= idx_nxt;
            if (start && !active) begin
                dly_q  <= dly_in;
                wait_q <= wait_in;
            end
        end
    end

    // R5: the cycle index never runs past the hold cycle
    a_r5_idx_bounded: assert property (@(posedge clk) disable iff (rst)
        active |-> (idx_q <= last_idx));

    // R6: latched delay never exceeds latched wait
    a_r6_dly_clamped: assert property (@(posedge clk) disable iff (rst)
        active |-> (dly_q <= wait_q));

endmodule

// File: rtl/smw_strobe_gen.sv
module smw_strobe_gen
    import smw_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 2,
    parameter int LANES     = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  phase_e               phase_nxt,
    input  logic [BANK_W-1:0]    bank_nxt,
    input  logic                 byte_nxt,
    output logic [NUM_BANKS-1:0] cs_n,
    output logic                 we_n,
    output logic [LANES-1:0]     lane_n,
    output logic                 done
);

    strobe_s intent;

    assign intent = intent_of(phase_nxt, byte_nxt);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
        always_ff @(posedge clk) begin
            if (rst) cs_n[b] <= 1'b1;
            else     cs_n[b] <= !(intent.cs && (bank_nxt == BANK_W'(b)));
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) lane_n[l] <= 1'b1;
            else     lane_n[l] <= !intent.lane;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            we_n <= 1'b1;
            done <= 1'b0;
        end else begin
            we_n <= !intent.we;
            done <= intent.done;
        end
    end

endmodule

// File: rtl/smw_write_seq.sv
module smw_write_seq
    import smw_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CNT_W     = 4,
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    parameter int LANES     = DATA_W / 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic [BANK_W-1:0]          req_bank,
    input  logic                       req_byte_mode,
    input  logic [NUM_BANKS*CNT_W-1:0] cfg_wen_dly,
    input  logic [NUM_BANKS*CNT_W-1:0] cfg_wr_wait,
    output logic [NUM_BANKS-1:0]       mem_cs_n,
    output logic [ADDR_W-1:0]          mem_addr,
    output logic [DATA_W-1:0]          mem_dout,
    output logic                       mem_we_n,
    output logic [LANES-1:0]           mem_lane_n,
    output logic                       done
);

    localparam int IDX_W = CNT_W + 2;

    typedef struct packed {
        logic [BANK_W-1:0] bank;
        logic              byte_mode;
    } ctl_s;

    logic             active;
    logic             accept;
    logic [CNT_W-1:0] dly_eff, wait_sel;
    phase_e           phase_nxt;
    ctl_s             ctl_q, ctl_nxt;

    assign accept  = req_valid && !active;
    assign ctl_nxt = accept ? ctl_s'{bank: req_bank, byte_mode: req_byte_mode} : ctl_q;

    smw_cfg_sel #(
        .NUM_BANKS(NUM_BANKS),
        .CNT_W    (CNT_W),
        .BANK_W   (BANK_W)
    ) cfg_i (
        .bank     (req_bank),
        .dly_flat (cfg_wen_dly),
        .wait_flat(cfg_wr_wait),
        .dly_eff  (dly_eff),
        .wait_sel (wait_sel)
    );

    smw_phase_ctr #(
        .CNT_W(CNT_W),
        .IDX_W(IDX_W)
    ) ctr_i (
        .clk      (clk),
        .rst      (rst),
        .start    (accept),
        .dly_in   (dly_eff),
        .wait_in  (wait_sel),
        .active   (active),
        .phase_nxt(phase_nxt)
    );

    smw_strobe_gen #(
        .NUM_BANKS(NUM_BANKS),
        .BANK_W   (BANK_W),
        .LANES    (LANES)
    ) strb_i (
        .clk      (clk),
        .rst      (rst),
        .phase_nxt(phase_nxt),
        .bank_nxt (ctl_nxt.bank),
        .byte_nxt (ctl_nxt.byte_mode),
        .cs_n     (mem_cs_n),
        .we_n     (mem_we_n),
        .lane_n   (mem_lane_n),
        .done     (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            mem_addr <= '0;
            mem_dout <= '0;
        end else if (accept) begin
            ctl_q    <= ctl_nxt;
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
        end
    end

    // R2: at most one chip select low
    a_r2_cs_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~mem_cs_n));

    // R3: no strobe in the first chip-select cycle
    a_r3_no_strobe_at_start: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_cs_n) && $past(&mem_cs_n)) |-> (mem_we_n && (&mem_lane_n)));

    // R4: a strobe only occurs while a chip select is low
    a_r4_strobe_inside_cs: assert property (@(posedge clk) disable iff (rst)
        (!mem_we_n || !(&mem_lane_n)) |-> !(&mem_cs_n));

    // R7: write strobe and lane strobes never both active
    a_r7_we_lane_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!mem_we_n && !(&mem_lane_n)));

    // R8: done lasts one cycle and chip select is released after it
    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && (&mem_cs_n)));

    // R8: done only during the hold cycle, with no strobe active
    a_r8_done_in_hold: assert property (@(posedge clk) disable iff (rst)
        done |-> (!(&mem_cs_n) && mem_we_n && (&mem_lane_n)));

    // R9: address and data stay put across an access
    a_r9_addr_held: assert property (@(posedge clk) disable iff (rst)
        (!(&mem_cs_n) && $past(!(&mem_cs_n))) |-> ($stable(mem_addr) && $stable(mem_dout)));

endmodule

// File: tb/smw_write_seq_tb.sv
`timescale 1ns/1ps
module smw_write_seq_tb_top;

    localparam int NB = 4;
    localparam int CW = 4;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int BW = 2;
    localparam int LN = DW / 8;

    logic              clk = 1'b0;
    logic              rst;
    logic              req_valid;
    logic [AW-1:0]     req_addr;
    logic [DW-1:0]     req_wdata;
    logic [BW-1:0]     req_bank;
    logic              req_byte_mode;
    logic [NB*CW-1:0]  cfg_wen_dly;
    logic [NB*CW-1:0]  cfg_wr_wait;
    logic [NB-1:0]     mem_cs_n;
    logic [AW-1:0]     mem_addr;
    logic [DW-1:0]     mem_dout;
    logic              mem_we_n;
    logic [LN-1:0]     mem_lane_n;
    logic              done;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    smw_write_seq #(
        .NUM_BANKS(NB), .CNT_W(CW), .ADDR_W(AW), .DATA_W(DW)
    ) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bank(req_bank), .req_byte_mode(req_byte_mode),
        .cfg_wen_dly(cfg_wen_dly), .cfg_wr_wait(cfg_wr_wait),
        .mem_cs_n(mem_cs_n), .mem_addr(mem_addr), .mem_dout(mem_dout),
        .mem_we_n(mem_we_n), .mem_lane_n(mem_lane_n), .done(done)
    );

    task automatic chk(input string req, input string what, input int cyc,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    endtask

    // Selected bank gets (d,w); other banks get differing values (R10)
    task automatic set_cfg(input int bank, input int d, input int w);
        for (int b = 0; b < NB; b++) begin
            if (b == bank) begin
                cfg_wen_dly[b*CW +: CW] = CW'(d);
                cfg_wr_wait[b*CW +: CW] = CW'(w);
            end else begin
                cfg_wen_dly[b*CW +: CW] = CW'((d + 3 + b) % 16);
                cfg_wr_wait[b*CW +: CW] = CW'((w + 5 + b) % 16);
            end
        end
    endtask

    // One access with a behavioural expectation per observed cycle
    task automatic run_access(input int bank, input int d, input int w,
                              input bit bmode, input bit poke);
        int de;
        logic [AW-1:0] a;
        logic [DW-1:0] dat;
        string wtag;
        de   = (d > w) ? w : d;
        wtag = (d > w) ? "R6" : "R3";
        a    = AW'($urandom);
        dat  = DW'($urandom);
        @(negedge clk);
        set_cfg(bank, d, w);
        req_valid     = 1'b1;
        req_addr      = a;
        req_wdata     = dat;
        req_bank      = BW'(bank);
        req_byte_mode = bmode;
        for (int k = 0; k <= 3 + w; k++) begin
            logic [NB-1:0] e_cs;
            logic          e_we, e_done, in_acc, strb;
            logic [LN-1:0] e_lane;
            @(negedge clk);
            req_valid = 1'b0;
            if (poke && (k == 1 || k == 2 + w)) begin
                req_valid     = 1'b1;
                req_bank      = BW'((bank + 1) % NB);
                req_addr      = ~a;
                req_wdata     = ~dat;
                req_byte_mode = ~bmode;
            end
            in_acc = (k <= 2 + w);
            strb   = (k >= 1 + de) && (k <= 1 + w);
            e_cs   = in_acc ? ~(NB'(1) << bank) : '1;
            e_we   = !(strb && !bmode);
            e_lane = (strb && bmode) ? '0 : '1;
            e_done = (k == 2 + w);
            chk(k == 3 + w ? (poke ? "R9" : "R5") : "R2", "cs_n", k, 32'(mem_cs_n), 32'(e_cs));
            chk(bmode ? "R7" : (k <= 1 + de ? wtag : "R4"), "we_n", k, 32'(mem_we_n), 32'(e_we));
            chk(bmode ? (k <= 1 + de ? wtag : "R4") : "R7", "lane_n", k, 32'(mem_lane_n), 32'(e_lane));
            chk("R8", "done", k, 32'(done), 32'(e_done));
            if (in_acc) begin
                chk(poke ? "R9" : "R2", "addr", k, 32'(mem_addr), 32'(a));
                chk(poke ? "R9" : "R2", "data", k, 32'(mem_dout), 32'(dat));
            end
        end
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        rst = 1'b1;
        req_valid = 1'b0;
        req_addr = '0;
        req_wdata = '0;
        req_bank = '0;
        req_byte_mode = 1'b0;
        cfg_wen_dly = '0;
        cfg_wr_wait = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: idle state after reset
        chk("R1", "cs_n", 0, 32'(mem_cs_n), 32'(NB'('1)));
        chk("R1", "we_n", 0, 32'(mem_we_n), 32'd1);
        chk("R1", "lane_n", 0, 32'(mem_lane_n), 32'(LN'('1)));
        chk("R1", "done", 0, 32'(done), 32'd0);

        // Full sweep of delay/wait settings, normal strobe mode (R3..R6, R10)
        for (int d = 0; d < 16; d++)
            for (int w = 0; w < 16; w++)
                run_access((d + 2 * w) % NB, d, w, 1'b0, ((d + w) % 3) == 0);

        // Same sweep in byte-lane mode (R7)
        for (int d = 0; d < 16; d++)
            for (int w = 0; w < 16; w++)
                run_access((3 * d + w) % NB, d, w, 1'b1, ((d + w) % 4) == 1);

        // R1: idle after the last access
        repeat (2) @(negedge clk);
        chk("R1", "cs_n", 0, 32'(mem_cs_n), 32'(NB'('1)));
        chk("R1", "done", 0, 32'(done), 32'd0);
        report();
    end

endmodule